// File: doc/BRIEF.md
# NAND Page Storage Engine

This block is the storage side of a small NAND flash model. It keeps every page of a parameterized number of erase blocks, each page followed by its spare bytes, in one on-chip byte array. A command decoder sits in front of it and issues three kinds of request: load a page into the page buffer, program the page buffer into a page, or erase a whole block. Between requests the same decoder pushes program data bytes into the page buffer and pulls read data bytes out of it.

A page load starts at a column. That column is the request column plus a pending offset that the decoder can set beforehand. The number of bytes made available depends on a spare-suppression input. When a sequential read drains the buffer, the next read request loads the following page. Requests take one cycle per byte moved. A one-cycle `done` pulse marks the end of each request, including requests that the engine ignores.

Top module: `nand_page_store`

## Requirements
- R1: Each page has a spare area of PAGE_BYTES/32 bytes, so a row holds PAGE_BYTES + PAGE_BYTES/32 bytes (264 by default). Erase blocks hold 16 pages for 256-byte pages, 32 pages for 512-byte pages and 64 pages for 2048-byte pages.
- R2: After power-up every stored byte reads 0xFF. After reset `busy`, `done` and `rd_valid` are 0, and `remain` is 0.
- R3: A load (`op_kind` = 2'b01) starts at column S = `op_col` + pending offset. It sets `remain` to ROW−S, or to PAGE_BYTES−S when `spare_off` is 1; the count is 0 if S is past that limit. Each `rd_req` then gives the next stored byte on `rd_data`, with `rd_valid` high on the following cycle, and lowers `remain` by one.
- R4: `bias_set` stores `bias_val` as the pending offset. A load or program that is carried out uses the offset and then clears it; this includes an automatic next-page load.
- R5: After a load, an `rd_req` that arrives with `remain` = 0 returns no byte (`rd_valid` stays 0). It loads page P+1 from column 0 plus the pending offset, where P is the last loaded page.
- R6: `buf_clear` empties the program buffer. Each `wr_valid` cycle then appends `wr_data`. Only the first ROW bytes are kept and any further bytes are dropped.
- R7: A program (`op_kind` = 2'b10) writes the buffered bytes in order from column `op_col` + pending offset. Bytes that would fall past the end of the row are dropped, and other bytes of the page keep their value. With the default AND_PROGRAM = 0 the new bytes overwrite the old ones.
- R8: An erase (`op_kind` = 2'b11) aligns `op_page` down to its block boundary and sets every data and spare byte of that block to 0xFF.
- R9: A request whose page number is NPAGES or more changes neither the array, the read state nor the pending offset, and still produces a `done` pulse.
- R10: `done` is a single-cycle pulse that follows the last byte moved by a request. `busy` is high while a request that moves bytes is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Request strobe, taken when idle |
| op_kind | input | 2 | 01 load, 10 program, 11 erase, 00 no request |
| op_page | input | PAGE_W | Page number of the request |
| op_col | input | COL_W | Column within the row |
| bias_set | input | 1 | Store bias_val as pending column offset |
| bias_val | input | COL_W | Pending column offset value |
| spare_off | input | 1 | Exclude spare bytes from load length |
| buf_clear | input | 1 | Empty the program buffer |
| wr_valid | input | 1 | Program data byte strobe |
| wr_data | input | 8 | Program data byte |
| rd_req | input | 1 | Read data byte request |
| rd_valid | output | 1 | rd_data holds a byte this cycle |
| rd_data | output | 8 | Read data byte |
| remain | output | COL_W | Bytes left in the loaded buffer |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the automatic next-page load. It needs a load at a column close to the end of the row, then a drain of every remaining byte, and then one more read request. On the last page the same read request must be ignored because the next page is out of range. The stimulus reaches these directly with high start columns and pending offsets. Random programs and loads at random columns, some with spare suppression and some with out-of-range pages, then mix buffer overflow and row-end truncation with reads that a byte-level model of the array predicts.

// File: rtl/nps_pkg.sv
`timescale 1ns/1ps
package nps_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_LOAD  = 2'b01,
      OP_PROG  = 2'b10,
      OP_ERASE = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOAD,
      ST_PROG,
      ST_ERASE
   } st_e;

   function automatic int spare_of(input int page_bytes);
      return page_bytes / 32;
   endfunction

   function automatic int ppb_of(input int page_bytes);
      return (page_bytes == 256) ? 16 : ((page_bytes == 512) ? 32 : 64);
   endfunction
endpackage

// File: rtl/nps_array.sv
`timescale 1ns/1ps
module nps_array #(
   parameter int DEPTH     = 4224,
   parameter int AW        = 13,
   parameter bit AND_MERGE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          merge,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);
   logic [7:0] cells [DEPTH];
   logic [7:0] next_val;

   initial begin
      for (int k = 0; k < DEPTH; k++) cells[k] = 8'hFF;
   end

   assign rdata = cells[addr];

   generate
      if (AND_MERGE) begin : g_and
         assign next_val = merge ? (rdata & wdata) : wdata;
      end else begin : g_over
         logic unused_merge;
         assign unused_merge = merge;
         assign next_val = wdata;
      end
   endgenerate

   always @(posedge clk) begin
      if (we) cells[addr] <= next_val;
   end

   AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(addr) < DEPTH)); // R9
endmodule

// File: rtl/nps_pagebuf.sv
`timescale 1ns/1ps
module nps_pagebuf #(
   parameter int ROW = 264,
   parameter int BW  = 9
) (
   input  logic          clk,
   input  logic          we,
   input  logic [BW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [BW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] slots [ROW];

   assign rdata = slots[raddr];

   always_ff @(posedge clk) begin
      if (we) slots[waddr] <= wdata;
   end
endmodule

// File: rtl/nps_ctrl.sv
`timescale 1ns/1ps
module nps_ctrl
   import nps_pkg::*;
#(
   parameter int PAGE_BYTES = 256,
   parameter int ROW        = 264,
   parameter int PPB        = 16,
   parameter int NPAGES     = 16,
   parameter int AW         = 13,
   parameter int BW         = 9,
   parameter int COL_W      = 9,
   parameter int PAGE_W     = 5,
   parameter int CNT_W      = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic [1:0]        op_kind,
   input  logic [PAGE_W-1:0] op_page,
   input  logic [COL_W-1:0]  op_col,
   input  logic              bias_set,
   input  logic [COL_W-1:0]  bias_val,
   input  logic              spare_off,
   input  logic              buf_clear,
   input  logic              wr_valid,
   input  logic [7:0]        wr_data,
   input  logic              rd_req,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic [COL_W-1:0]  remain,
   output logic              busy,
   output logic              done,
   output logic              arr_we,
   output logic              arr_merge,
   output logic [AW-1:0]     arr_addr,
   output logic [7:0]        arr_wdata,
   input  logic [7:0]        arr_rdata,
   output logic              buf_we,
   output logic [BW-1:0]     buf_waddr,
   output logic [7:0]        buf_wdata,
   output logic [BW-1:0]     buf_raddr,
   input  logic [7:0]        buf_rdata
);
   localparam int PPB_W = $clog2(PPB);
   localparam logic [COL_W-1:0] ROW_C  = COL_W'(ROW);
   localparam logic [COL_W:0]   LIM_PG = (COL_W+1)'(PAGE_BYTES);
   localparam logic [COL_W:0]   LIM_RW = (COL_W+1)'(ROW);

   st_e               st;
   logic [CNT_W-1:0]  idx, last;
   logic [AW-1:0]     base;
   logic [COL_W:0]    startc;
   logic [COL_W-1:0]  bias_q, remain_q, rd_ptr, wr_cnt;
   logic              rmode;
   logic [PAGE_W-1:0] cur_pg;
   logic              done_q, rdv_q;
   logic [7:0]        rdd_q;

   // request decode, only while idle
   logic              idle, go_op, go_adv, go_rd, req_ok;
   op_e               req_kind;
   logic [PAGE_W-1:0] req_pg, blk_pg;
   logic [COL_W-1:0]  req_col;
   logic [COL_W:0]    req_start, lim, ld_len;
   logic [CNT_W:0]    colpos;

   assign idle      = (st == ST_IDLE);
   assign go_op     = idle && op_start && (op_e'(op_kind) != OP_NONE);
   assign go_adv    = idle && !op_start && rd_req && rmode && (remain_q == '0);
   assign go_rd     = idle && !op_start && rd_req && rmode && (remain_q != '0);
   assign req_kind  = go_op ? op_e'(op_kind) : OP_LOAD;
   assign req_pg    = go_op ? op_page : cur_pg + 1'b1;
   assign req_col   = go_op ? op_col : '0;
   assign req_ok    = (req_pg < PAGE_W'(NPAGES));
   assign req_start = (COL_W+1)'(req_col) + (COL_W+1)'(bias_q);
   assign lim       = spare_off ? LIM_PG : LIM_RW;
   assign ld_len    = (req_start < lim) ? (lim - req_start) : '0;
   assign blk_pg    = {req_pg[PAGE_W-1:PPB_W], PPB_W'(0)};
   assign colpos    = (CNT_W+1)'(startc) + (CNT_W+1)'(idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE;   idx <= '0;      last <= '0;    base <= '0;
         startc <= '0;    bias_q <= '0;   remain_q <= '0;
         rd_ptr <= '0;    wr_cnt <= '0;   rmode <= 1'b0; cur_pg <= '0;
         done_q <= 1'b0;  rdv_q <= 1'b0;  rdd_q <= '0;
      end else begin
         done_q <= 1'b0;
         rdv_q  <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (bias_set) bias_q <= bias_val;
               if (buf_clear) wr_cnt <= '0;
               else if (wr_valid && (wr_cnt < ROW_C)) wr_cnt <= wr_cnt + 1'b1;
               if (go_rd) begin
                  rdd_q    <= buf_rdata;
                  rdv_q    <= 1'b1;
                  rd_ptr   <= rd_ptr + 1'b1;
                  remain_q <= remain_q - 1'b1;
               end
               if (go_op || go_adv) begin
                  idx <= '0;
                  if (!req_ok) begin
                     done_q <= 1'b1;
                  end else begin
                     case (req_kind)
                        OP_LOAD: begin
                           bias_q   <= '0;
                           startc   <= req_start;
                           base     <= AW'(req_pg) * AW'(ROW);
                           cur_pg   <= req_pg;
                           rmode    <= 1'b1;
                           rd_ptr   <= '0;
                           remain_q <= COL_W'(ld_len);
                           if (ld_len == '0) done_q <= 1'b1;
                           else begin
                              last <= CNT_W'(ld_len) - 1'b1;
                              st   <= ST_LOAD;
                           end
                        end
                        OP_PROG: begin
                           bias_q <= '0;
                           rmode  <= 1'b0;
                           startc <= req_start;
                           base   <= AW'(req_pg) * AW'(ROW);
                           if (wr_cnt == '0) done_q <= 1'b1;
                           else begin
                              last <= CNT_W'(wr_cnt) - 1'b1;
                              st   <= ST_PROG;
                           end
                        end
                        default: begin
                           rmode  <= 1'b0;
                           startc <= '0;
                           base   <= AW'(blk_pg) * AW'(ROW);
                           last   <= CNT_W'(PPB * ROW - 1);
                           st     <= ST_ERASE;
                        end
                     endcase
                  end
               end
            end
            default: begin
               if (idx == last) begin
                  st     <= ST_IDLE;
                  done_q <= 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
         endcase
      end
   end

   assign arr_addr  = base + AW'(startc) + AW'(idx);
   assign arr_we    = ((st == ST_PROG) && (colpos < (CNT_W+1)'(ROW))) || (st == ST_ERASE);
   assign arr_merge = (st == ST_PROG);
   assign arr_wdata = (st == ST_ERASE) ? 8'hFF : buf_rdata;

   assign buf_raddr = (st == ST_PROG) ? BW'(idx) : BW'(rd_ptr);
   assign buf_we    = (st == ST_LOAD) ||
                      (idle && wr_valid && !buf_clear && (wr_cnt < ROW_C));
   assign buf_waddr = (st == ST_LOAD) ? BW'(idx) : BW'(wr_cnt);
   assign buf_wdata = (st == ST_LOAD) ? arr_rdata : wr_data;

   assign rd_valid = rdv_q;
   assign rd_data  = rdd_q;
   assign remain   = remain_q;
   assign busy     = !idle;
   assign done     = done_q;

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R10
   AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R10
   AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (remain_q == $past(remain_q) - 1'b1)); // R3
   AST_REMAIN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      remain_q <= ROW_C); // R3
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt <= ROW_C); // R6
endmodule

// File: rtl/nand_page_store.sv
`timescale 1ns/1ps
module nand_page_store
   import nps_pkg::*;
#(
   parameter int PAGE_BYTES  = 256,
   parameter int NUM_BLOCKS  = 1,
   parameter bit AND_PROGRAM = 1'b0,
   localparam int ROW    = PAGE_BYTES + spare_of(PAGE_BYTES),
   localparam int PPB    = ppb_of(PAGE_BYTES),
   localparam int NPAGES = PPB * NUM_BLOCKS,
   localparam int DEPTH  = NPAGES * ROW,
   localparam int AW     = $clog2(DEPTH),
   localparam int BW     = $clog2(ROW),
   localparam int COL_W  = $clog2(ROW + 1),
   localparam int PAGE_W = $clog2(NPAGES) + 1,
   localparam int CNT_W  = $clog2(PPB * ROW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic [1:0]        op_kind,
   input  logic [PAGE_W-1:0] op_page,
   input  logic [COL_W-1:0]  op_col,
   input  logic              bias_set,
   input  logic [COL_W-1:0]  bias_val,
   input  logic              spare_off,
   input  logic              buf_clear,
   input  logic              wr_valid,
   input  logic [7:0]        wr_data,
   input  logic              rd_req,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic [COL_W-1:0]  remain,
   output logic              busy,
   output logic              done
);
   generate
      if (!(PAGE_BYTES == 256 || PAGE_BYTES == 512 || PAGE_BYTES == 2048)) begin : g_bad_page
         $error("nand_page_store: PAGE_BYTES must be 256, 512 or 2048");
      end
      if (NUM_BLOCKS < 1) begin : g_bad_blocks
         $error("nand_page_store: NUM_BLOCKS must be at least 1");
      end
   endgenerate

   logic          arr_we, arr_merge;
   logic [AW-1:0] arr_addr;
   logic [7:0]    arr_wdata, arr_rdata;
   logic          buf_we;
   logic [BW-1:0] buf_waddr, buf_raddr;
   logic [7:0]    buf_wdata, buf_rdata;

   nps_ctrl #(
      .PAGE_BYTES(PAGE_BYTES), .ROW(ROW), .PPB(PPB), .NPAGES(NPAGES),
      .AW(AW), .BW(BW), .COL_W(COL_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .op_start(op_start), .op_kind(op_kind), .op_page(op_page), .op_col(op_col),
      .bias_set(bias_set), .bias_val(bias_val), .spare_off(spare_off),
      .buf_clear(buf_clear), .wr_valid(wr_valid), .wr_data(wr_data),
      .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
      .remain(remain), .busy(busy), .done(done),
      .arr_we(arr_we), .arr_merge(arr_merge), .arr_addr(arr_addr),
      .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
      .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
      .buf_raddr(buf_raddr), .buf_rdata(buf_rdata)
   );

   nps_array #(.DEPTH(DEPTH), .AW(AW), .AND_MERGE(AND_PROGRAM)) u_array (
      .clk(clk), .rst_n(rst_n), .we(arr_we), .merge(arr_merge),
      .addr(arr_addr), .wdata(arr_wdata), .rdata(arr_rdata)
   );

   nps_pagebuf #(.ROW(ROW), .BW(BW)) u_buf (
      .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
      .raddr(buf_raddr), .rdata(buf_rdata)
   );
endmodule

// File: tb/nand_page_store_test.sv
`timescale 1ns/1ps
module nand_page_store_test;
   localparam int PAGE   = 256;
   localparam int ROW    = 264;
   localparam int PPB    = 16;
   localparam int NPAGES = 16;
   localparam int DEPTH  = NPAGES * ROW;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_start = 1'b0;
   logic [1:0] op_kind = 2'b00;
   logic [4:0] op_page = '0;
   logic [8:0] op_col = '0;
   logic       bias_set = 1'b0;
   logic [8:0] bias_val = '0;
   logic       spare_off = 1'b0;
   logic       buf_clear = 1'b0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_req = 1'b0;
   logic       rd_valid, busy, done;
   logic [7:0] rd_data;
   logic [8:0] remain;

   int checks = 0;
   int errs = 0;

   logic [7:0] m  [DEPTH];
   logic [7:0] eb [ROW];
   logic [7:0] wb [ROW];
   int wcnt = 0, bias_m = 0, cur_m = 0, rem_m = 0;
   bit rmode_m = 1'b0;

   nand_page_store uut (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
      .op_page(op_page), .op_col(op_col), .bias_set(bias_set), .bias_val(bias_val),
      .spare_off(spare_off), .buf_clear(buf_clear), .wr_valid(wr_valid),
      .wr_data(wr_data), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
      .remain(remain), .busy(busy), .done(done)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   // model of a load of page pg starting at column st
   task automatic model_load(input int pg, input int st, input bit soff);
      int lim = soff ? PAGE : ROW;
      bias_m  = 0;
      cur_m   = pg;
      rmode_m = 1'b1;
      rem_m   = (st < lim) ? lim - st : 0;
      for (int k = 0; k < rem_m; k++) eb[k] = m[pg * ROW + st + k];
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 6000) begin
         @(negedge clk);
         n++;
      end
      chk(req, "done seen", {31'd0, done}, 32'd1);
      @(negedge clk);
      chk("R10", "done one cycle", {31'd0, done}, 32'd0);
   endtask

   task automatic do_op(input int kind, input int pg, input int col, input bit soff,
                        input string req);
      int st;
      @(negedge clk);
      op_start = 1'b1; op_kind = 2'(kind); op_page = 5'(pg); op_col = 9'(col);
      spare_off = soff;
      @(negedge clk);
      op_start = 1'b0; op_kind = 2'b00;
      wait_done(req);
      if (pg < NPAGES) begin
         st = col + bias_m;
         if (kind == 1) model_load(pg, st, soff);
         else if (kind == 2) begin
            bias_m = 0; rmode_m = 1'b0;
            for (int k = 0; k < wcnt; k++)
               if (st + k < ROW) m[pg * ROW + st + k] = wb[k];
         end else if (kind == 3) begin
            rmode_m = 1'b0;
            for (int k = (pg / PPB) * PPB * ROW; k < ((pg / PPB) + 1) * PPB * ROW; k++)
               m[k] = 8'hFF;
         end
      end
      if (kind == 1) chk(req, "remain after load", 32'(remain), 32'(rem_m));
   endtask

   task automatic set_bias(input int v);
      @(negedge clk);
      bias_set = 1'b1; bias_val = 9'(v);
      @(negedge clk);
      bias_set = 1'b0;
      bias_m = v;
   endtask

   task automatic fill(input int n, input bit rnd, input logic [7:0] fixed);
      @(negedge clk);
      buf_clear = 1'b1;
      @(negedge clk);
      buf_clear = 1'b0;
      wcnt = 0;
      for (int k = 0; k < n; k++) begin
         wr_valid = 1'b1;
         wr_data = rnd ? 8'($urandom) : fixed;
         if (wcnt < ROW) begin
            wb[wcnt] = wr_data;
            wcnt++;
         end
         @(negedge clk);
      end
      wr_valid = 1'b0;
   endtask

   task automatic read_all(input string req);
      int n = rem_m;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         rd_req = 1'b1;
         @(negedge clk);
         rd_req = 1'b0;
         chk(req, "rd_valid", {31'd0, rd_valid}, 32'd1);
         chk(req, "rd_data", {24'd0, rd_data}, {24'd0, eb[k]});
         rem_m--;
      end
      chk(req, "remain drained", 32'(remain), 32'd0);
   endtask

   task automatic advance(input string req);
      @(negedge clk);
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      chk("R5", "no byte on advance", {31'd0, rd_valid}, 32'd0);
      wait_done(req);
      if (cur_m + 1 < NPAGES) model_load(cur_m + 1, bias_m, spare_off);
      chk(req, "remain after advance", 32'(remain), 32'(rem_m));
   endtask

   initial begin
      #(20 * 150000);
      errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int k = 0; k < DEPTH; k++) m[k] = 8'hFF;
      repeat (3) @(negedge clk);
      // R2 reset state
      chk("R2", "busy", {31'd0, busy}, 32'd0);
      chk("R2", "done", {31'd0, done}, 32'd0);
      chk("R2", "rd_valid", {31'd0, rd_valid}, 32'd0);
      chk("R2", "remain", 32'(remain), 32'd0);
      rst_n = 1'b1;

      // R2 R1 R3: erased page, full row with spare
      do_op(1, 3, 0, 1'b0, "R1");
      read_all("R2");

      // R7 R3: program a run and read it back from a column
      fill(10, 1'b1, 8'h00);
      do_op(2, 2, 5, 1'b0, "R7");
      do_op(1, 2, 3, 1'b0, "R3");
      read_all("R7");

      // R7 overwrite: writing 0xFF over data gives 0xFF
      fill(4, 1'b0, 8'hFF);
      do_op(2, 2, 5, 1'b0, "R7");
      do_op(1, 2, 0, 1'b0, "R7");
      read_all("R7");

      // R3 spare suppression
      do_op(1, 2, 4, 1'b1, "R3");
      chk("R3", "suppressed length", 32'(remain), 32'(PAGE - 4));
      read_all("R3");

      // R4 pending offset into the spare, then cleared
      set_bias(256);
      do_op(1, 2, 0, 1'b0, "R4");
      chk("R4", "spare-only length", 32'(remain), 32'd8);
      read_all("R4");
      do_op(1, 2, 0, 1'b0, "R4");
      chk("R4", "offset cleared", 32'(remain), 32'(ROW));
      set_bias(256);
      do_op(1, 2, 0, 1'b1, "R3");
      chk("R3", "past limit gives zero", 32'(remain), 32'd0);

      // R6 overflow and R7 row-end drop
      fill(300, 1'b1, 8'h00);
      do_op(2, 7, 0, 1'b0, "R6");
      do_op(1, 7, 0, 1'b0, "R6");
      read_all("R6");
      fill(20, 1'b1, 8'h00);
      set_bias(200);
      do_op(2, 8, 50, 1'b0, "R7");
      do_op(1, 8, 240, 1'b0, "R7");
      read_all("R7");

      // R5 automatic next page
      do_op(1, 6, 260, 1'b0, "R5");
      read_all("R5");
      advance("R5");
      read_all("R5");
      // R4 offset also used by the advance
      do_op(1, 1, 263, 1'b0, "R5");
      read_all("R5");
      set_bias(250);
      advance("R4");
      read_all("R4");

      // R9 advance past the last page is ignored
      do_op(1, 15, 262, 1'b0, "R9");
      read_all("R9");
      advance("R9");
      chk("R9", "remain stays zero", 32'(remain), 32'd0);

      // R9 out-of-range program and erase leave data alone
      fill(8, 1'b1, 8'h00);
      do_op(2, 20, 0, 1'b0, "R9");
      do_op(3, 16, 0, 1'b0, "R9");
      do_op(1, 7, 0, 1'b0, "R9");
      read_all("R9");

      // R8 erase from a page in the middle of the block
      do_op(3, 9, 0, 1'b0, "R8");
      for (int p = 0; p < NPAGES; p += 5) begin
         do_op(1, p, 0, 1'b0, "R8");
         read_all("R8");
      end
      do_op(1, 7, 0, 1'b0, "R8");
      read_all("R8");

      // random mix
      for (int it = 0; it < 30; it++) begin
         int pg  = $urandom_range(0, NPAGES + 3);
         int col = $urandom_range(0, ROW - 1);
         if ($urandom_range(0, 3) == 0) set_bias($urandom_range(0, 100));
         fill($urandom_range(1, 40), 1'b1, 8'h00);
         do_op(2, pg, col, 1'b0, "R7");
         if (it % 12 == 11) do_op(3, $urandom_range(0, NPAGES - 1), 0, 1'b0, "R8");
         do_op(1, $urandom_range(0, NPAGES - 1), $urandom_range(0, ROW - 1),
               1'($urandom_range(0, 1)), "R3");
         read_all("R3");
      end

      finish_run();
   end
endmodule